// File: doc/BRIEF.md
# Composite Branch Path Confidence Estimator

This block tells a branch-directed lookahead engine how far it can trust the speculative path it is walking. The engine follows one predicted branch at a time. For each branch it supplies an index into a local-history table and an index into a global-history table, together with the direction predictor's own 2-bit saturating counters. The block adds the two table counters and the predictor counters into a confidence number. That number selects one of a set of accuracy buckets. The bucket holds the measured accuracy of past branches that produced the same number, and that accuracy is returned as the confidence of the branch.

The per-branch confidences are multiplied along the path into a path confidence, held as unsigned Q0.8 fixed point with 1.0 encoded as 256. The path confidence is compared with a threshold that grows with lookahead depth. When it falls below that threshold, the block raises a stall so that the engine stops running ahead. When branches resolve, their indices, counters and outcome train both tables and the bucket statistics. Every fixed number of resolved branches, the bucket accuracies are recomputed from the statistics.

Top module: `path_conf_est`

## Requirements
- R1: The local table has LDEPTH (default 1024) entries of 5-bit counters, all zero after reset. A resolve with upd_correct=1 increments the entry at upd_lidx, saturating at 31. A resolve with upd_correct=0 halves it (shift right by one).
- R2: The global table has GDEPTH (default 4096) entries of 3-bit counters, all zero after reset. A resolve with upd_correct=1 increments the entry at upd_gidx, saturating at 7. A resolve with upd_correct=0 clears it to zero.
- R3: conf_idx is the sum of local[pred_lidx], global[pred_gidx] and the two 2-bit fields of pred_ctr (bits 1:0 and 3:2), clamped to NBKT-1 (43). It is combinational, and in a cycle that also carries a resolve it shows the table values from before that resolve.
- R4: Each resolve counts one prediction in the bucket its update-side sum selects, using the same sum and clamp as R3 on the update indices and upd_ctr. A correct outcome also counts one hit. When the total is at its maximum (2^SCW-1), the total and the hit count are both halved before the new prediction is counted.
- R5: Resolves are counted modulo INTERVAL. On the clock edge after the edge that takes the INTERVAL-th resolve, every bucket whose total is nonzero sets its ratio to floor(hits*256/total). A bucket with a zero total keeps its ratio. Ratios change at no other time, and they are all 256 after reset.
- R6: br_conf is the current ratio of bucket conf_idx, combinationally.
- R7: On an edge with pred_valid=1 and path_restart=0, path_conf becomes floor(path_conf*br_conf/256) and the depth count rises by one, saturating at MAXD (8). path_restart=1 sets path_conf to 256 and the depth to 0, and it takes precedence over pred_valid in the same cycle.
- R8: lookahead_stall is 1 exactly when path_conf < min(THR_BASE + THR_STEP*depth, 256), with defaults THR_BASE=32 and THR_STEP=24.
- R9: After reset, path_conf is 256, the depth is 0, lookahead_stall is 0 and every ratio is 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A lookahead branch is accepted this cycle |
| pred_lidx | input | 10 | Local-history table index at prediction |
| pred_gidx | input | 12 | Global-history table index at prediction |
| pred_ctr | input | 4 | Two 2-bit predictor counters at prediction |
| path_restart | input | 1 | Lookahead restarts; path returns to full confidence |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_lidx | input | 10 | Local-history index of the resolving branch |
| upd_gidx | input | 12 | Global-history index of the resolving branch |
| upd_ctr | input | 4 | Predictor counters of the resolving branch |
| upd_correct | input | 1 | The resolving branch was predicted correctly |
| conf_idx | output | 6 | Confidence number (bucket index) of the lookahead branch |
| br_conf | output | 9 | Q0.8 confidence of the lookahead branch |
| path_conf | output | 9 | Q0.8 running path confidence |
| lookahead_stall | output | 1 | Path confidence is below the threshold for the current depth |

## Verification
The assertions assume that every input is driven to a known level on each rising edge and that at most one resolve arrives per cycle. Their write-back checks compare a table entry against its value one cycle earlier, which also assumes that the update side never carries unknown indices. The bench changes inputs only on the falling edge and holds every input at zero when it is not in use. It sets the refresh interval to eight and the bucket counts to four bits, so that refreshes and count halving happen within short sequences. It drives indices only inside the table sizes.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int QW   = 9;
  localparam int QONE = 256;
  typedef logic [QW-1:0] q8_t;

  // floor(hits*256/total), caller guarantees total > 0
  function automatic q8_t ratio_q8(int hits, int total);
    int r;
    r = (hits * QONE) / total;
    if (r > QONE) r = QONE;
    return q8_t'(r);
  endfunction

  // truncating Q0.8 multiply; operands never exceed 1.0
  function automatic q8_t mul_q8(q8_t a, q8_t b);
    logic [2*QW-1:0] p;
    p = (2*QW)'(a) * (2*QW)'(b);
    return q8_t'(p >> 8);
  endfunction

  function automatic q8_t depth_thr(int depth, int base, int step);
    int t;
    t = base + step * depth;
    if (t > QONE) t = QONE;
    return q8_t'(t);
  endfunction
endpackage

// File: rtl/pce_ctr_table.sv
module pce_ctr_table #(
  parameter int DEPTH = 1024,
  parameter int CW    = 5,
  parameter bit HALVE = 1'b1,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] p_idx,
  output logic [CW-1:0] p_val,
  input  logic          u_en,
  input  logic [IW-1:0] u_idx,
  input  logic          u_ok,
  output logic [CW-1:0] u_val
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] tbl [DEPTH];
  logic [CW-1:0] miss_val;
  logic [CW-1:0] nxt_val;

  assign p_val = tbl[p_idx];
  assign u_val = tbl[u_idx];

  generate
    if (HALVE) begin : g_halve
      assign miss_val = u_val >> 1;
      // R1: a miss leaves half the former value
      assert_miss_halves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (u_en && !u_ok) |=> (tbl[$past(u_idx)] == ($past(u_val) >> 1)));
    end else begin : g_clear
      assign miss_val = '0;
      // R2: a miss empties the entry
      assert_miss_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (u_en && !u_ok) |=> (tbl[$past(u_idx)] == '0));
    end
  endgenerate

  assign nxt_val = u_ok ? ((u_val == CMAX) ? CMAX : u_val + 1'b1) : miss_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (u_en) begin
      tbl[u_idx] <= nxt_val;
    end
  end

  // R1 and R2: a hit never lowers the entry
  assert_hit_no_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (u_en && u_ok) |=> (tbl[$past(u_idx)] >= $past(u_val)));
endmodule

// File: rtl/pce_bucket_stats.sv
module pce_bucket_stats
  import pce_pkg::*;
#(
  parameter int NBKT     = 44,
  parameter int SCW      = 10,
  parameter int INTERVAL = 1024,
  localparam int BW      = $clog2(NBKT),
  localparam int CNW     = $clog2(INTERVAL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     u_en,
  input  logic [BW-1:0]            u_bkt,
  input  logic                     u_ok,
  output logic [NBKT-1:0][QW-1:0]  ratio
);
  localparam logic [SCW-1:0] SMAX = '1;
  localparam logic [CNW-1:0] LAST = CNW'(INTERVAL - 1);

  logic [SCW-1:0] tot [NBKT];
  logic [SCW-1:0] hit [NBKT];
  logic [CNW-1:0] icnt;
  logic           refresh;      // interval just ended
  logic           at_max;

  assign at_max = (tot[u_bkt] == SMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBKT; b++) begin
        tot[b] <= '0;
        hit[b] <= '0;
      end
      icnt    <= '0;
      refresh <= 1'b0;
    end else begin
      refresh <= u_en && (icnt == LAST);
      if (u_en) begin
        icnt <= (icnt == LAST) ? '0 : icnt + 1'b1;
        if (at_max) begin
          tot[u_bkt] <= (tot[u_bkt] >> 1) + 1'b1;
          hit[u_bkt] <= (hit[u_bkt] >> 1) + SCW'(u_ok);
        end else begin
          tot[u_bkt] <= tot[u_bkt] + 1'b1;
          hit[u_bkt] <= hit[u_bkt] + SCW'(u_ok);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBKT; b++) ratio[b] <= q8_t'(QONE);
    end else if (refresh) begin
      for (int b = 0; b < NBKT; b++)
        if (tot[b] != '0) ratio[b] <= ratio_q8(int'(hit[b]), int'(tot[b]));
    end
  end

  // R5: ratios move only on the refresh cycle
  assert_ratio_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(ratio));
  // R4: hits never exceed the total of a bucket
  assert_hits_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    u_en |=> (hit[$past(u_bkt)] <= tot[$past(u_bkt)]));
  // R4: a counted bucket is never left empty, even after halving
  assert_total_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    u_en |=> (tot[$past(u_bkt)] != '0));
endmodule

// File: rtl/pce_path_acc.sv
module pce_path_acc
  import pce_pkg::*;
#(
  parameter int MAXD     = 8,
  parameter int THR_BASE = 32,
  parameter int THR_STEP = 24,
  localparam int DW      = $clog2(MAXD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p_en,
  input  logic restart,
  input  q8_t  br_conf,
  output q8_t  path,
  output logic stall
);
  localparam logic [DW-1:0] DMAX = DW'(MAXD);

  logic [DW-1:0] depth;
  q8_t           thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path  <= q8_t'(QONE);
      depth <= '0;
    end else if (restart) begin
      path  <= q8_t'(QONE);
      depth <= '0;
    end else if (p_en) begin
      path  <= mul_q8(path, br_conf);
      depth <= (depth == DMAX) ? depth : depth + 1'b1;
    end
  end

  assign thr   = depth_thr(int'(depth), THR_BASE, THR_STEP);
  assign stall = (path < thr);

  // R7: restart returns to full confidence at depth zero
  assert_restart_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (path == q8_t'(QONE) && depth == '0));
  // R7: accumulating a branch never raises the path value
  assert_path_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_en && !restart) |=> (path <= $past(path)));
  // R7: depth stays within its cap
  assert_depth_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth <= DMAX));
endmodule

// File: rtl/path_conf_est.sv
module path_conf_est
  import pce_pkg::*;
#(
  parameter int LDEPTH   = 1024,
  parameter int LCW      = 5,
  parameter int GDEPTH   = 4096,
  parameter int GCW      = 3,
  parameter int NPRED    = 2,
  parameter int NBKT     = 44,
  parameter int SCW      = 10,
  parameter int INTERVAL = 1024,
  parameter int MAXD     = 8,
  parameter int THR_BASE = 32,
  parameter int THR_STEP = 24,
  localparam int LIW     = $clog2(LDEPTH),
  localparam int GIW     = $clog2(GDEPTH),
  localparam int PCW     = 2 * NPRED,
  localparam int BW      = $clog2(NBKT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pred_valid,
  input  logic [LIW-1:0] pred_lidx,
  input  logic [GIW-1:0] pred_gidx,
  input  logic [PCW-1:0] pred_ctr,
  input  logic           path_restart,
  input  logic           upd_valid,
  input  logic [LIW-1:0] upd_lidx,
  input  logic [GIW-1:0] upd_gidx,
  input  logic [PCW-1:0] upd_ctr,
  input  logic           upd_correct,
  output logic [BW-1:0]  conf_idx,
  output logic [QW-1:0]  br_conf,
  output logic [QW-1:0]  path_conf,
  output logic           lookahead_stall
);
  logic [LCW-1:0] p_loc, u_loc;
  logic [GCW-1:0] p_glb, u_glb;
  logic [BW-1:0]  u_bkt;
  logic [NBKT-1:0][QW-1:0] ratio;

  function automatic logic [BW-1:0] bucket_of(int l, int g, logic [PCW-1:0] c);
    int s;
    s = l + g;
    for (int k = 0; k < NPRED; k++) s = s + int'(c[2*k +: 2]);
    if (s > NBKT - 1) s = NBKT - 1;
    return BW'(s);
  endfunction

  pce_ctr_table #(.DEPTH(LDEPTH), .CW(LCW), .HALVE(1'b1)) u_loc_tbl (
    .clk(clk), .rst_n(rst_n),
    .p_idx(pred_lidx), .p_val(p_loc),
    .u_en(upd_valid), .u_idx(upd_lidx), .u_ok(upd_correct), .u_val(u_loc));

  pce_ctr_table #(.DEPTH(GDEPTH), .CW(GCW), .HALVE(1'b0)) u_glb_tbl (
    .clk(clk), .rst_n(rst_n),
    .p_idx(pred_gidx), .p_val(p_glb),
    .u_en(upd_valid), .u_idx(upd_gidx), .u_ok(upd_correct), .u_val(u_glb));

  assign conf_idx = bucket_of(int'(p_loc), int'(p_glb), pred_ctr);
  assign u_bkt    = bucket_of(int'(u_loc), int'(u_glb), upd_ctr);

  pce_bucket_stats #(.NBKT(NBKT), .SCW(SCW), .INTERVAL(INTERVAL)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .u_en(upd_valid), .u_bkt(u_bkt), .u_ok(upd_correct), .ratio(ratio));

  assign br_conf = ratio[conf_idx];

  pce_path_acc #(.MAXD(MAXD), .THR_BASE(THR_BASE), .THR_STEP(THR_STEP)) u_path (
    .clk(clk), .rst_n(rst_n),
    .p_en(pred_valid), .restart(path_restart), .br_conf(br_conf),
    .path(path_conf), .stall(lookahead_stall));
endmodule

// File: tb/sim_path_conf_est.sv
`timescale 1ns/1ps
module sim_path_conf_est;
  localparam int IVL  = 8;
  localparam int TMAX = 15;

  typedef struct packed {
    logic pv; logic [9:0] pl; logic [11:0] pg; logic [3:0] pc;
    logic uv; logic [9:0] ul; logic [11:0] ug; logic [3:0] uc;
    logic ok; logic rs;
  } vec_t;

  function automatic vec_t mk(int pv, int pl, int pg, int pc,
                              int uv, int ul, int ug, int uc, int ok, int rs);
    vec_t r;
    r.pv = pv[0]; r.pl = 10'(pl); r.pg = 12'(pg); r.pc = 4'(pc);
    r.uv = uv[0]; r.ul = 10'(ul); r.ug = 12'(ug); r.uc = 4'(uc);
    r.ok = ok[0]; r.rs = rs[0];
    return r;
  endfunction

  localparam vec_t VECS [16] = '{
    mk(0,0,0,0,   1,1,1,0,1,0),
    mk(1,1,1,0,   1,1,1,0,1,0),
    mk(1,1,1,0,   1,1,1,0,0,0),
    mk(1,1,1,5,   1,2,2,3,0,0),
    mk(1,2,2,3,   1,1,1,0,1,0),
    mk(0,0,0,0,   1,7,7,15,1,0),
    mk(1,7,7,15,  1,7,7,15,1,0),
    mk(1,7,7,15,  1,7,7,15,0,0),
    mk(1,1,1,0,   0,0,0,0,0,0),
    mk(1,7,7,15,  0,0,0,0,0,0),
    mk(1,1,1,0,   1,1,1,0,0,1),
    mk(1,2,2,3,   1,3,3,1,1,0),
    mk(1,1,1,5,   1,3,3,1,0,0),
    mk(1,3,3,1,   1,1,1,5,1,0),
    mk(0,0,0,0,   0,0,0,0,0,1),
    mk(1,7,7,15,  1,2,2,3,1,0)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pred_valid = 0, path_restart = 0, upd_valid = 0, upd_correct = 0;
  logic [9:0] pred_lidx = 0, upd_lidx = 0;
  logic [11:0] pred_gidx = 0, upd_gidx = 0;
  logic [3:0] pred_ctr = 0, upd_ctr = 0;
  logic [5:0] conf_idx;
  logic [8:0] br_conf, path_conf;
  logic lookahead_stall;

  int checks = 0, errors = 0;
  bit done = 0;

  int lm [1024];
  int gm [4096];
  int tot [44], hit [44], rat [44];
  int mcnt, mpend, mpath, mdep;

  always #10 clk = ~clk;

  path_conf_est #(.SCW(4), .INTERVAL(IVL)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_lidx(pred_lidx),
    .pred_gidx(pred_gidx), .pred_ctr(pred_ctr), .path_restart(path_restart),
    .upd_valid(upd_valid), .upd_lidx(upd_lidx), .upd_gidx(upd_gidx),
    .upd_ctr(upd_ctr), .upd_correct(upd_correct), .conf_idx(conf_idx),
    .br_conf(br_conf), .path_conf(path_conf), .lookahead_stall(lookahead_stall));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mbkt(int l, int g, logic [3:0] c);
    int s;
    s = lm[l] + gm[g] + int'(c[1:0]) + int'(c[3:2]);
    return (s > 43) ? 43 : s;
  endfunction

  function automatic int mthr(int d);
    int t;
    t = 32 + 24 * d;
    return (t > 256) ? 256 : t;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) lm[i] = 0;
    for (int i = 0; i < 4096; i++) gm[i] = 0;
    for (int b = 0; b < 44; b++) begin tot[b] = 0; hit[b] = 0; rat[b] = 256; end
    mcnt = 0; mpend = 0; mpath = 256; mdep = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    pred_valid = 0; path_restart = 0; upd_valid = 0; upd_correct = 0;
    model_clear();
    @(negedge clk);
    rst_n = 1;
  endtask

  // entry and exit at a falling edge
  task automatic step(input vec_t v, input string tag);
    int ep, eu;
    pred_valid = v.pv; pred_lidx = v.pl; pred_gidx = v.pg; pred_ctr = v.pc;
    upd_valid = v.uv; upd_lidx = v.ul; upd_gidx = v.ug; upd_ctr = v.uc;
    upd_correct = v.ok; path_restart = v.rs;
    #2;
    ep = mbkt(int'(v.pl), int'(v.pg), v.pc);
    eu = mbkt(int'(v.ul), int'(v.ug), v.uc);
    chk({tag, " R3 conf_idx"}, int'(conf_idx), ep);
    chk({tag, " R6 br_conf"}, int'(br_conf), rat[ep]);
    chk({tag, " R8 stall"}, int'(lookahead_stall), (mpath < mthr(mdep)) ? 1 : 0);
    @(posedge clk);
    if (v.rs) begin mpath = 256; mdep = 0; end
    else if (v.pv) begin
      mpath = (mpath * rat[ep]) / 256;
      mdep = (mdep == 8) ? 8 : mdep + 1;
    end
    if (mpend != 0)
      for (int b = 0; b < 44; b++) if (tot[b] != 0) rat[b] = (hit[b] * 256) / tot[b];
    mpend = 0;
    if (v.uv) begin
      if (tot[eu] == TMAX) begin
        tot[eu] = tot[eu] / 2 + 1; hit[eu] = hit[eu] / 2 + int'(v.ok);
      end else begin
        tot[eu] = tot[eu] + 1; hit[eu] = hit[eu] + int'(v.ok);
      end
      if (v.ok) begin
        lm[v.ul] = (lm[v.ul] >= 31) ? 31 : lm[v.ul] + 1;
        gm[v.ug] = (gm[v.ug] >= 7) ? 7 : gm[v.ug] + 1;
      end else begin
        lm[v.ul] = lm[v.ul] / 2;
        gm[v.ug] = 0;
      end
      if (mcnt == IVL - 1) begin mcnt = 0; mpend = 1; end
      else mcnt = mcnt + 1;
    end
    @(negedge clk);
    chk({tag, " R7 path_conf"}, int'(path_conf), mpath);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #2;
    // R9 reset state
    chk("R9 path_conf", int'(path_conf), 256);
    chk("R9 stall", int'(lookahead_stall), 0);
    chk("R9 br_conf", int'(br_conf), 256);

    foreach (VECS[i]) step(VECS[i], "vec");

    // R1 and R2: saturate both tables at one pair of indices
    for (int i = 0; i < 36; i++) step(mk(1,50,60,0, 1,50,60,0,1,0), "R1 sat");
    step(mk(1,50,60,15, 0,0,0,0,0,0), "R3 clamp");
    chk("R3 clamp literal", int'(conf_idx), 43);
    // one miss: local halves to 15, global clears
    step(mk(0,0,0,0, 1,50,60,0,0,0), "R2 miss");
    step(mk(1,50,60,0, 0,0,0,0,0,1), "R1 halve");
    chk("R1 halve literal", int'(conf_idx), 15);

    // R4 and R5: overflow bucket 0 with misses, then refresh
    for (int i = 0; i < 24; i++) step(mk(0,0,0,0, 1,100,200,0,0,0), "R4 halving");
    step(mk(0,0,0,0, 0,0,0,0,0,0), "R5 refresh");
    step(mk(1,100,200,0, 0,0,0,0,0,0), "R5 ratio");
    chk("R5 zero ratio literal", int'(br_conf), 0);

    // R7 and R8: restart wins over pred; then drive into stall
    step(mk(1,100,200,0, 0,0,0,0,0,1), "R7 restart priority");
    chk("R7 restart literal", int'(path_conf), 256);
    for (int i = 0; i < 10; i++) step(mk(1,50,60,0, 0,0,0,0,0,0), "R8 depth");
    step(mk(1,100,200,0, 0,0,0,0,0,0), "R8 stall");
    #2;
    chk("R8 stall literal", int'(lookahead_stall), 1);

    // R9 reset mid-run
    do_reset();
    #2;
    chk("R9 path after reset", int'(path_conf), 256);
    chk("R9 stall after reset", int'(lookahead_stall), 0);
    step(mk(1,50,60,0, 0,0,0,0,0,0), "R9 tables cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule